// File: doc/BRIEF.md
# Synchronous Burst Flash Read Controller

This block is the host side of a 16-bit synchronous burst NOR flash read path. A request carries a 22-bit word address, a burst-length code and a mode bit. The controller turns each request into strobe sequences on the flash pins: chip select, output enable, write enable (never asserted), address-valid, flash reset, and a flash clock derived from the system clock. Every sampled data word is presented with a one-cycle valid pulse.

In burst mode the start address is latched by a one-cycle low pulse on address-valid. After a programmable initial latency, one word is taken on every rising flash-clock edge. Bursts of 4, 8 or 16 words end by themselves. A continuous burst runs until it is stopped. Any burst can be ended in three ways: deselecting the chip, pulsing the flash reset, or latching a new address for a new burst.

In asynchronous mode the flash clock stays low. Output enable is held low for a configurable number of system cycles, and one word is then sampled. The target is assumed to power up in read-array mode, so reads need no command phase.

Top module: `bflash_rd_ctrl`

## Requirements
- R1: After reset, chip select, output enable, address-valid, write enable and flash reset are all high. The flash clock is low, `rd_valid` is low and `req_ready` is high.
- R2: Write enable is never driven low. The first request accepted after reset starts an address latch in the very next cycle, with no command phase.
- R3: An address latch lasts exactly one cycle. In that cycle chip select and address-valid are low, output enable is high, the flash clock is low and `fl_addr` equals the accepted `req_addr`. Address-valid returns high in the following cycle.
- R4: During the latency and data phases of a burst, the flash clock toggles on every system cycle, with chip select and output enable low and address-valid high. The flash clock is low in every other phase.
- R5: The first burst word is sampled at the L-th rising flash-clock edge after address-valid rises. L is `cfg_latency`, and values 0 and 1 count as 2.
- R6: After the first word, one word is sampled at each rising flash-clock edge. Successive words come from consecutive addresses, wrapping at 22 bits. Each word appears as a one-cycle `rd_valid` pulse on the cycle after its sampling edge.
- R7: `req_len` codes 0, 1, 2 and 3 mean 4 words, 8 words, 16 words and continuous. Once the last word of a finite burst is sampled, chip select and output enable are high in the cycle where that word is presented, and the controller is idle.
- R8: `abort_req` with `abort_rst`=0 makes chip select and output enable high on the next cycle. No further word is presented, even if that edge would have sampled one.
- R9: `abort_req` with `abort_rst`=1 holds the flash reset low for exactly RST_CYCLES cycles with chip select and output enable high, then returns to idle. No word is presented.
- R10: A request accepted during the latency or data phase of a burst ends that burst, which presents no further word. A new address latch follows at once, and the new burst returns words from the new address.
- R11: In asynchronous mode, address-valid pulses low for one cycle and the flash clock stays low. Output enable is then low for exactly W cycles, where W is `cfg_async_wait` and 0 counts as 1. Exactly one word is sampled at the end of that window, and all strobes are high in the cycle that word is presented.
- R12: `req_ready` is high in idle and in the latency and data phases of a burst. It is low during an address latch, during an asynchronous read and during a flash reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | 22 | Start word address |
| req_len | input | 2 | Burst length code (4/8/16/continuous) |
| req_burst | input | 1 | 1 = clocked burst, 0 = asynchronous single read |
| req_ready | output | 1 | Request can be accepted this cycle |
| cfg_latency | input | 3 | Initial burst latency in flash clocks |
| cfg_async_wait | input | 4 | Asynchronous output-enable window in system cycles |
| abort_req | input | 1 | End the current access |
| abort_rst | input | 1 | With abort_req: end by flash reset instead of deselect |
| rd_data | output | 16 | Sampled data word |
| rd_valid | output | 1 | rd_data holds a new word this cycle |
| fl_clk | output | 1 | Flash burst clock |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_avd_n | output | 1 | Flash address-valid, active low |
| fl_rst_n | output | 1 | Flash reset, active low |
| fl_addr | output | 22 | Flash address bus |
| fl_dq_i | input | 16 | Flash data bus, read side |

## Verification
A behavioural flash model counts rising flash-clock edges after each address-valid rise and returns a word that depends on that count. A controller with the wrong latency, or one that drops or repeats an edge, therefore returns wrong data and not merely late data. The bench tests the latency clamp (a setting of 1), the largest latency, and address wrap at the top of the 22-bit space. Bursts that are aborted or restarted are stopped exactly on an edge that would otherwise sample a word, so a controller that lets capture win over termination shows up as an unexpected extra word. The asynchronous path is checked by counting output-enable cycles, which catches an off-by-one wait or a wait of zero that is not clamped. The reset abort is checked by measuring the length of the reset pulse.

// File: rtl/bfr_pkg.sv
// Package: shared types and helpers for the burst flash read controller.
// Assumes: length code 3 selects an unbounded (continuous) burst.
package bfr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // deselected, waiting for a request
        ST_ALAT  = 3'd1,   // burst address latch cycle
        ST_LAT   = 3'd2,   // initial latency, flash clock running
        ST_BURST = 3'd3,   // one word per rising flash clock
        ST_AADR  = 3'd4,   // asynchronous address latch cycle
        ST_AWAIT = 3'd5,   // asynchronous output-enable window
        ST_RST   = 3'd6    // flash reset pulse
    } bfr_state_e;

    localparam logic [1:0] LEN_CONT = 2'd3;

    // Word count for a length code; 0 stands for continuous.
    function automatic logic [4:0] len_words(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd4;
            2'd1:    return 5'd8;
            2'd2:    return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/bfr_timer.sv
// Module: loadable down-counter shared by the latency, asynchronous wait
// and reset-pulse phases. Assumes load and dec are never needed together
// for different purposes; load wins.
module bfr_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_one
);

    logic [W-1:0] cnt_q;

    // Count register: load on phase entry, step down while the phase runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign is_one = (cnt_q == W'(1));

endmodule

// File: rtl/bfr_seq.sv
// Module: access sequencer. Owns the phase state, the flash clock,
// the word counter and the capture decision. Assumes cfg inputs are
// stable while an access is running. Abort beats restart beats capture.
module bfr_seq
    import bfr_pkg::*;
#(
    parameter int WAIT_W     = 4,
    parameter int RST_CYCLES = 4,
    parameter int TMR_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_burst,
    input  logic [1:0]        req_len,
    input  logic [2:0]        cfg_latency,
    input  logic [WAIT_W-1:0] cfg_async_wait,
    input  logic              abort_req,
    input  logic              abort_rst,
    output bfr_state_e        state_o,
    output logic              fl_clk,
    output logic              capture,
    output logic              accept,
    output logic              req_ready
);

    bfr_state_e        state_q, state_d;
    logic              clk_q;
    logic [4:0]        rem_q;
    logic              cont_q;
    logic              tmr_one, tmr_load, tmr_dec;
    logic [TMR_W-1:0]  tmr_val;
    logic              abort_now, rise_now, lat_done, running_d, running_q;
    logic [2:0]        lat_eff;
    logic [WAIT_W-1:0] wait_eff;

    assign lat_eff  = (cfg_latency < 3'd2) ? 3'd2 : cfg_latency;
    assign wait_eff = (cfg_async_wait == '0) ? WAIT_W'(1) : cfg_async_wait;

    assign req_ready = (state_q == ST_IDLE) || (state_q == ST_LAT) || (state_q == ST_BURST);
    assign abort_now = abort_req && (state_q != ST_IDLE) && (state_q != ST_RST);
    assign accept    = req_valid && req_ready && !abort_now;
    assign running_q = (state_q == ST_LAT) || (state_q == ST_BURST);
    assign rise_now  = running_q && !clk_q;
    assign lat_done  = (state_q == ST_LAT) && rise_now && tmr_one;

    // Capture decision: a rising flash edge in the data phase or the last latency edge, or the end of the async window.
    assign capture = !abort_now && !accept &&
                     (((state_q == ST_BURST) && rise_now) || lat_done ||
                      ((state_q == ST_AWAIT) && tmr_one));

    // Timer control: load on entry to a timed phase, count inside it.
    assign tmr_load = accept || (abort_now && abort_rst);
    assign tmr_val  = (abort_now && abort_rst) ? TMR_W'(RST_CYCLES) :
                      (req_burst ? TMR_W'(lat_eff) : TMR_W'(wait_eff));
    assign tmr_dec  = ((state_q == ST_LAT) && rise_now) ||
                      (state_q == ST_AWAIT) || (state_q == ST_RST);

    bfr_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .is_one   (tmr_one)
    );

    // Next phase: abort first, then restart or new request, then phase progress.
    always_comb begin
        state_d = state_q;
        if (abort_now)
            state_d = abort_rst ? ST_RST : ST_IDLE;
        else if (accept)
            state_d = req_burst ? ST_ALAT : ST_AADR;
        else begin
            case (state_q)
                ST_ALAT:  state_d = ST_LAT;
                ST_LAT:   if (lat_done) state_d = ST_BURST;
                ST_BURST: if (capture && !cont_q && rem_q == 5'd1) state_d = ST_IDLE;
                ST_AADR:  state_d = ST_AWAIT;
                ST_AWAIT: if (tmr_one) state_d = ST_IDLE;
                ST_RST:   if (tmr_one) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    assign running_d = (state_d == ST_LAT) || (state_d == ST_BURST);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Flash clock: toggles while staying in latency/data phases, parked low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                      clk_q <= 1'b0;
        else if (running_q && running_d) clk_q <= ~clk_q;
        else                             clk_q <= 1'b0;
    end

    // Word counter: loaded with the burst length on accept, decremented per captured word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            cont_q <= 1'b0;
        end else if (accept) begin
            rem_q  <= len_words(req_len);
            cont_q <= (req_len == LEN_CONT);
        end else if (capture && rem_q != '0) begin
            rem_q  <= rem_q - 1'b1;
        end
    end

    assign state_o = state_q;
    assign fl_clk  = clk_q;

    AST_REM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !cont_q) |-> (rem_q != '0)); // R7
    AST_CLK_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        clk_q |=> !clk_q); // R4
    AST_ASYNC_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AADR || state_q == ST_AWAIT) |-> !clk_q); // R11
    AST_ABORT_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_now |-> !capture); // R8

endmodule

// File: rtl/bfr_strobe.sv
// Module: decodes the phase into the active-low flash strobes.
// Assumes phases are registered, so the strobes change only after clock edges.
module bfr_strobe
    import bfr_pkg::*;
(
    input  bfr_state_e state,
    output logic       ce_n,
    output logic       oe_n,
    output logic       avd_n,
    output logic       frst_n
);

    // Strobe decode: select in every access phase, enable only while the flash drives data.
    always_comb begin
        ce_n   = !(state inside {ST_ALAT, ST_LAT, ST_BURST, ST_AADR, ST_AWAIT});
        oe_n   = !(state inside {ST_LAT, ST_BURST, ST_AWAIT});
        avd_n  = !(state inside {ST_ALAT, ST_AADR});
        frst_n = (state != ST_RST);
    end

endmodule

// File: rtl/bflash_rd_ctrl.sv
// Module: top of the burst flash read controller. Registers the flash
// address on accept and samples returned words. Assumes the flash powers
// up in read-array mode and that fl_dq_i is valid at each sampling edge.
module bflash_rd_ctrl
    import bfr_pkg::*;
#(
    parameter int ADDR_W     = 22,
    parameter int DATA_W     = 16,
    parameter int WAIT_W     = 4,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_len,
    input  logic              req_burst,
    output logic              req_ready,
    input  logic [2:0]        cfg_latency,
    input  logic [WAIT_W-1:0] cfg_async_wait,
    input  logic              abort_req,
    input  logic              abort_rst,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              fl_clk,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic              fl_avd_n,
    output logic              fl_rst_n,
    output logic [ADDR_W-1:0] fl_addr,
    input  logic [DATA_W-1:0] fl_dq_i
);

    localparam int RW    = $clog2(RST_CYCLES + 1);
    localparam int T1    = (RW > WAIT_W) ? RW : WAIT_W;
    localparam int TMR_W = (T1 > 3) ? T1 : 3;

    bfr_state_e state;
    logic       capture, accept;

    bfr_seq #(.WAIT_W(WAIT_W), .RST_CYCLES(RST_CYCLES), .TMR_W(TMR_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_burst      (req_burst),
        .req_len        (req_len),
        .cfg_latency    (cfg_latency),
        .cfg_async_wait (cfg_async_wait),
        .abort_req      (abort_req),
        .abort_rst      (abort_rst),
        .state_o        (state),
        .fl_clk         (fl_clk),
        .capture        (capture),
        .accept         (accept),
        .req_ready      (req_ready)
    );

    bfr_strobe u_strobe (
        .state  (state),
        .ce_n   (fl_ce_n),
        .oe_n   (fl_oe_n),
        .avd_n  (fl_avd_n),
        .frst_n (fl_rst_n)
    );

    assign fl_we_n = 1'b1;

    // Address register: holds the start address presented during the latch cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      fl_addr <= '0;
        else if (accept) fl_addr <= req_addr;
    end

    // Read-data register: samples the bus on capture and flags it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= fl_dq_i;
        end
    end

    AST_AVD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_avd_n |=> fl_avd_n); // R3
    AST_AVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_avd_n |-> (fl_oe_n && !fl_clk && !fl_ce_n)); // R3
    AST_CLK_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        fl_clk |-> (!fl_ce_n && !fl_oe_n && fl_avd_n)); // R4
    AST_RST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_rst_n |-> (fl_ce_n && fl_oe_n && !fl_clk)); // R9
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R6
    AST_WORD_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !$past(fl_oe_n)); // R11
    AST_ACCEPT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !abort_req) |=> !fl_avd_n); // R2

endmodule

// File: tb/bflash_rd_ctrl_tb_top.sv
// Scoreboard bench: driver tasks push expected words, a monitor pops and compares.
module bflash_rd_ctrl_tb_top;

    localparam int RSTC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [21:0] req_addr = '0;
    logic [1:0]  req_len = '0;
    logic        req_burst = 1'b0;
    logic        req_ready;
    logic [2:0]  cfg_latency = 3'd2;
    logic [3:0]  cfg_async_wait = 4'd1;
    logic        abort_req = 1'b0;
    logic        abort_rst = 1'b0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        fl_clk, fl_ce_n, fl_oe_n, fl_we_n, fl_avd_n, fl_rst_n;
    logic [21:0] fl_addr;
    logic [15:0] fl_dq;

    int nchk = 0;
    int nfail = 0;
    logic [15:0] expq[$];
    logic        tb_async = 1'b0;
    int          exp_w = 1;
    int          leff = 2;

    always #2 clk = ~clk;

    bflash_rd_ctrl #(.RST_CYCLES(RSTC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_burst(req_burst), .req_ready(req_ready),
        .cfg_latency(cfg_latency), .cfg_async_wait(cfg_async_wait),
        .abort_req(abort_req), .abort_rst(abort_rst), .rd_data(rd_data),
        .rd_valid(rd_valid), .fl_clk(fl_clk), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
        .fl_we_n(fl_we_n), .fl_avd_n(fl_avd_n), .fl_rst_n(fl_rst_n),
        .fl_addr(fl_addr), .fl_dq_i(fl_dq)
    );

    function automatic logic [15:0] pat(input logic [21:0] a);
        return a[15:0] ^ {a[21:16], 10'h2B5};
    endfunction

    // Flash model: latches on address-valid rise, counts rising clock edges.
    logic [21:0] base = '0;
    int          edges = 0;
    logic        prev_avd = 1'b1, prev_clk = 1'b0;
    always @(negedge clk) begin
        if (!prev_avd && fl_avd_n && !fl_ce_n) begin
            base  <= fl_addr;
            edges <= 0;
        end else if (!prev_clk && fl_clk && !fl_ce_n && fl_avd_n) begin
            edges <= edges + 1;
        end
        prev_avd <= fl_avd_n;
        prev_clk <= fl_clk;
    end
    assign fl_dq = (!fl_ce_n && !fl_oe_n) ?
                   (tb_async ? pat(base) : pat(base + 22'(edges - (leff - 1)))) : 16'hDEAD;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected words, checks async output-enable window length.
    int oe_run = 0;
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R6/R8/R10 unexpected word", {16'h0, rd_data}, 32'h0);
            end else begin
                logic [15:0] e;
                e = expq.pop_front();
                chk(rd_data == e, tb_async ? "R11 async word" : "R4 R5 R6 burst word",
                    {16'h0, rd_data}, {16'h0, e});
                if (tb_async)
                    chk(oe_run == exp_w, "R11 oe window", oe_run, exp_w);
            end
        end
        if (!fl_oe_n) oe_run++;
        else          oe_run = 0;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic send_req(input logic [21:0] a, input logic [1:0] len, input bit burst);
        req_addr  = a;
        req_len   = len;
        req_burst = burst;
        req_valid = 1'b1;
        while (!req_ready) step();
        step();
        req_valid = 1'b0;
    endtask

    task automatic push_words(input logic [21:0] a, input int n);
        for (int i = 0; i < n; i++) expq.push_back(pat(a + 22'(i)));
    endtask

    task automatic wait_drain(input string req);
        int guard = 0;
        while (expq.size() != 0 && guard < 400) begin
            step();
            guard++;
        end
        chk(expq.size() == 0, req, expq.size(), 0);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (!(fl_ce_n && fl_rst_n && req_ready) && guard < 400) begin
            step();
            guard++;
        end
    endtask

    task automatic burst_fixed(input logic [21:0] a, input logic [1:0] len, input int n, input logic [2:0] lat);
        tb_async    = 1'b0;
        cfg_latency = lat;
        leff        = (lat < 3'd2) ? 2 : int'(lat);
        push_words(a, n);
        send_req(a, len, 1'b1);
        wait_drain("R7 burst length");
        chk(fl_ce_n && fl_oe_n, "R7 released after last word", {fl_ce_n, fl_oe_n}, 2'b11);
        repeat (6) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1: reset state
        chk(fl_ce_n && fl_oe_n && fl_avd_n && fl_we_n && fl_rst_n,
            "R1 strobes high", {fl_ce_n, fl_oe_n, fl_avd_n, fl_we_n, fl_rst_n}, 5'h1F);
        chk(!fl_clk && !rd_valid && req_ready, "R1 clk/valid/ready",
            {fl_clk, rd_valid, req_ready}, 3'b001);

        // R2 R3: first request latches immediately, one latch cycle
        tb_async = 1'b0; cfg_latency = 3'd2; leff = 2;
        push_words(22'h000100, 4);
        send_req(22'h000100, 2'd0, 1'b1);
        chk(!fl_ce_n && !fl_avd_n && fl_oe_n && !fl_clk && fl_we_n, "R2 R3 latch cycle",
            {fl_ce_n, fl_avd_n, fl_oe_n, fl_clk, fl_we_n}, 5'b00101);
        chk(fl_addr == 22'h000100, "R3 latch address", fl_addr, 22'h000100);
        step();
        chk(fl_avd_n && !fl_ce_n, "R3 avd released", {fl_avd_n, fl_ce_n}, 2'b10);
        wait_drain("R7 len4");
        chk(fl_ce_n && fl_oe_n, "R7 released after last word", {fl_ce_n, fl_oe_n}, 2'b11);
        repeat (4) step();

        // R5 R6 R7: max latency and address wrap; clamp of latency 1; 16 words
        burst_fixed(22'h3FFFFC, 2'd1, 8, 3'd7);
        burst_fixed(22'h0A5A50, 2'd2, 16, 3'd1);

        // R11 R12: asynchronous reads, W=3 and W=0 (clamped to 1)
        tb_async = 1'b1;
        cfg_async_wait = 4'd3; exp_w = 3;
        push_words(22'h123456, 1);
        send_req(22'h123456, 2'd0, 1'b0);
        step();
        chk(!req_ready && !fl_oe_n, "R12 not ready in async wait", {req_ready, fl_oe_n}, 2'b00);
        wait_drain("R11 async word count");
        chk(fl_ce_n && fl_oe_n && fl_avd_n, "R11 strobes released", {fl_ce_n, fl_oe_n, fl_avd_n}, 3'b111);
        repeat (4) step();
        cfg_async_wait = 4'd0; exp_w = 1;
        push_words(22'h2ABCDE, 1);
        send_req(22'h2ABCDE, 2'd0, 1'b0);
        wait_drain("R11 async clamp");
        repeat (4) step();
        tb_async = 1'b0;

        // R8: continuous burst ended by deselect
        cfg_latency = 3'd3; leff = 3;
        push_words(22'h001000, 20);
        send_req(22'h001000, 2'd3, 1'b1);
        wait_drain("R7 continuous");
        chk(req_ready, "R12 ready during burst", req_ready, 1);
        abort_req = 1'b1; abort_rst = 1'b0;
        step();
        abort_req = 1'b0;
        chk(fl_ce_n && fl_oe_n && !fl_clk, "R8 deselect", {fl_ce_n, fl_oe_n, fl_clk}, 3'b110);
        repeat (10) step();

        // R9: continuous burst ended by flash reset
        push_words(22'h002000, 6);
        send_req(22'h002000, 2'd3, 1'b1);
        wait_drain("R9 pre-abort words");
        abort_req = 1'b1; abort_rst = 1'b1;
        step();
        abort_req = 1'b0;
        begin
            int n = 0;
            bit sel_ok = 1'b1;
            while (!fl_rst_n && n < 50) begin
                n++;
                if (!fl_ce_n) sel_ok = 1'b0;
                step();
            end
            chk(n == RSTC, "R9 reset pulse length", n, RSTC);
            chk(sel_ok, "R9 deselected during reset", sel_ok, 1);
        end
        wait_idle();
        repeat (6) step();

        // R10: restart with a new address mid-burst
        push_words(22'h003000, 5);
        send_req(22'h003000, 2'd3, 1'b1);
        wait_drain("R10 first burst words");
        push_words(22'h155550, 4);
        send_req(22'h155550, 2'd0, 1'b1);
        chk(!fl_avd_n && !fl_ce_n && fl_addr == 22'h155550, "R10 new latch",
            fl_addr, 22'h155550);
        wait_drain("R10 new burst words");
        repeat (10) step();

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule